// File: doc/BRIEF.md
# Configurable UART Transmitter

This block turns characters into asynchronous serial frames on a single output line. Software-side logic writes a character into a one-entry holding buffer. When the shift stage is free and the start conditions are met, the character is moved into the shift stage. It is then sent as one start bit, 7 to 9 character bits least significant bit first, an optional parity bit, and one or two stop bits.

A bit-rate generator sets the width of each bit. It counts qualifying cycles of a source tick and closes a bit after 16(n+1) of them, where n is an 8-bit divisor that is captured when a frame starts. The start of a frame can be held back by a transmit enable and, when gating is on, by a clear-to-send input.

The interrupt fires on one of two selectable events: when a character leaves the buffer, or when a frame finishes. Two inversion modes are available. One inverts only the character bits. The other inverts every level on the line, including idle.

Top module: `uart_tx_core`

## Requirements
- R1: After reset the line rests at its idle level of 1 (0 when `line_inv` is 1), `buf_empty` is 1 and `irq` is 0.
- R2: A write is accepted only while the buffer is empty. A write while it is full is dropped, and the character already held is sent unchanged.
- R3: A frame starts only when `tx_en` is 1, the buffer is full, and either `cts_gate_en` is 0 or `cts_n` is 0. In the cycle after a write, the buffer is seen as full; if the conditions hold, the start bit appears one cycle later.
- R4: Every bit lasts exactly 16(n+1) cycles in which `src_tick` is 1. Here n is the value of `divisor` sampled when the frame starts. Cycles with `src_tick` at 0 do not count.
- R5: A frame begins with one start bit of 0, followed by the character bits least significant first. `char_len` gives the count: 00 = 7, 01 = 8, 10 = 9, 11 = 8.
- R6: `par_mode` 01 appends a bit that makes the count of ones in the character and parity bits even. 10 makes that count odd. 00 and 11 append no parity bit. Parity is taken over the character bits as they are sent.
- R7: The frame ends with one stop bit of 1, or two when `two_stop` is 1.
- R8: With `irq_sel` at 0, `irq` is a one-cycle pulse in the cycle after a character moves from the buffer into the shift stage.
- R9: With `irq_sel` at 1, `irq` is a one-cycle pulse in the cycle after the last stop bit ends.
- R10: With `payload_inv` at 1, only the character bits are inverted. Start, parity and stop bits keep their normal levels.
- R11: With `line_inv` at 1, every level on `txd` is inverted, including idle.
- R12: If the buffer is full and the conditions of R3 hold when the last stop bit ends, the next start bit follows in the very next cycle, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | 1 | Qualifies the cycles counted by the bit-rate generator |
| divisor | input | 8 | Rate divisor n; a bit lasts 16(n+1) ticks |
| char_len | input | 2 | Character length select (00=7, 01=8, 10=9, 11=8) |
| par_mode | input | 2 | Parity select (00 none, 01 even, 10 odd, 11 none) |
| two_stop | input | 1 | 1 selects two stop bits |
| payload_inv | input | 1 | Invert character bits only |
| line_inv | input | 1 | Invert every level driven on txd |
| tx_en | input | 1 | Transmit enable |
| cts_gate_en | input | 1 | 1 makes frame start wait for cts_n low |
| cts_n | input | 1 | Clear-to-send, active low |
| irq_sel | input | 1 | Interrupt cause: 0 on buffer take, 1 on frame end |
| wr_valid | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 9 | Character to write |
| buf_empty | output | 1 | 1 while the holding buffer is empty |
| txd | output | 1 | Serial output line |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Some rules are checked by assertions on every cycle:
- the bit counter never passes its limit and restarts at each frame;
- a full buffer keeps its character;
- the buffer only drains under the start conditions;
- each frame opens with a low start bit, including a frame that follows another with no gap;
- each interrupt pulse matches the cause selected in the cycle before.

The exact bit sequence can only be shown by the bench's cycle-accurate model, compared on every clock. That sequence covers character length, parity value, stop count, both inversions, the bit width under a paused tick, and the gap-free hand-over between frames.

// File: rtl/utx_pkg.sv
package utx_pkg;
    localparam int OVERSAMPLE = 16;

    localparam logic [1:0] LEN_SHORT = 2'b00;
    localparam logic [1:0] LEN_MID   = 2'b01;
    localparam logic [1:0] LEN_FULL  = 2'b10;

    localparam logic [1:0] PAR_EVEN  = 2'b01;
    localparam logic [1:0] PAR_ODD   = 2'b10;

    localparam logic LINE_IDLE  = 1'b1;
    localparam logic LINE_START = 1'b0;
    localparam logic LINE_STOP  = 1'b1;
endpackage

// File: rtl/utx_baud_gen.sv
module utx_baud_gen #(
    parameter int DIV_W = 8,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_tick,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] divisor,
    output logic             bit_end
);
    localparam int OVS_W = $clog2(OVS);
    localparam int CNT_W = DIV_W + OVS_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
    } baud_st_t;

    baud_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        bit_end = run && src_tick && (st_q.cnt == st_q.lim);
        if (restart) begin
            st_d.cnt = '0;
            st_d.lim = CNT_W'(((CNT_W+1)'(divisor) + (CNT_W+1)'(1)) * (CNT_W+1)'(OVS)
                              - (CNT_W+1)'(1));
        end else if (bit_end) begin
            st_d.cnt = '0;
        end else if (run && src_tick) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: the tick counter stays within the captured bit length
    p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.lim);

    // R4: each new frame starts its first bit from a cleared count
    p_restart_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> st_q.cnt == '0);
endmodule

// File: rtl/utx_hold_buf.sv
module utx_hold_buf #(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] data
);
    typedef struct packed {
        logic          full;
        logic [DW-1:0] data;
    } buf_st_t;

    buf_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.full = 1'b0;
        end else if (wr_valid && !st_q.full) begin
            st_d.full = 1'b1;
            st_d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full = st_q.full;
    assign data = st_q.data;

    // R2: a held character survives any write until it is taken
    p_full_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.full && !take) |=> (st_q.full && $stable(st_q.data)));
endmodule

// File: rtl/utx_frame_shift.sv
module utx_frame_shift
    import utx_pkg::*;
#(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          bit_end,
    input  logic [DW-1:0] data,
    input  logic [1:0]    char_len,
    input  logic [1:0]    par_mode,
    input  logic          two_stop,
    input  logic          payload_inv,
    output logic          busy,
    output logic          line,
    output logic          frame_done
);
    localparam int FRAME_W = DW + 4;
    localparam int REM_W   = $clog2(FRAME_W);
    localparam int LEN_W   = $clog2(DW + 1);

    typedef struct packed {
        logic               busy;
        logic               line;
        logic [FRAME_W-2:0] rest;
        logic [REM_W-1:0]   rem;
    } sh_st_t;

    sh_st_t st_d, st_q;

    logic [LEN_W-1:0]   nchar;
    logic [DW-1:0]      chars;
    logic               par_en;
    logic               par_bit;
    logic [FRAME_W-1:0] frame;
    logic [REM_W-1:0]   nbits;

    // Character count from the length select
    always_comb begin
        case (char_len)
            LEN_SHORT: nchar = LEN_W'(DW - 2);
            LEN_FULL:  nchar = LEN_W'(DW);
            default:   nchar = LEN_W'(DW - 1);
        endcase
    end

    // Frame image: start, characters, optional parity, stop bits
    always_comb begin
        chars   = '0;
        for (int i = 0; i < DW; i++) begin
            if (LEN_W'(i) < nchar) chars[i] = data[i] ^ payload_inv;
        end
        par_en  = (par_mode == PAR_EVEN) || (par_mode == PAR_ODD);
        par_bit = (^chars) ^ (par_mode == PAR_ODD);
        frame   = {FRAME_W{LINE_STOP}};
        frame[0] = LINE_START;
        for (int i = 0; i < DW; i++) begin
            if (LEN_W'(i) < nchar) frame[1 + i] = chars[i];
        end
        if (par_en) frame[REM_W'(nchar) + REM_W'(1)] = par_bit;
        nbits = REM_W'(nchar) + REM_W'(par_en) + REM_W'(two_stop) + REM_W'(2);
    end

    assign frame_done = st_q.busy && bit_end && (st_q.rem == '0);

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.busy = 1'b1;
            st_d.line = frame[0];
            st_d.rest = frame[FRAME_W-1:1];
            st_d.rem  = nbits - REM_W'(1);
        end else if (frame_done) begin
            st_d.busy = 1'b0;
            st_d.line = LINE_IDLE;
        end else if (st_q.busy && bit_end) begin
            st_d.line = st_q.rest[0];
            st_d.rest = {LINE_STOP, st_q.rest[FRAME_W-2:1]};
            st_d.rem  = st_q.rem - REM_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.line <= LINE_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign line = st_q.line;

    // R5: a frame leaving idle opens with a low start bit
    p_start_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> (st_q.line == LINE_START));

    // R12: a frame handed over at the end of another starts at once
    p_no_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && load) |=> (st_q.busy && st_q.line == LINE_START));
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core #(
    parameter int DW    = 9,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_tick,
    input  logic [DIV_W-1:0] divisor,
    input  logic [1:0]       char_len,
    input  logic [1:0]       par_mode,
    input  logic             two_stop,
    input  logic             payload_inv,
    input  logic             line_inv,
    input  logic             tx_en,
    input  logic             cts_gate_en,
    input  logic             cts_n,
    input  logic             irq_sel,
    input  logic             wr_valid,
    input  logic [DW-1:0]    wr_data,
    output logic             buf_empty,
    output logic             txd,
    output logic             irq
);
    typedef struct packed {
        logic irq;
    } top_st_t;

    top_st_t       st_d, st_q;
    logic          buf_full;
    logic [DW-1:0] buf_data;
    logic          busy;
    logic          line;
    logic          frame_done;
    logic          bit_end;
    logic          load;

    utx_hold_buf #(.DW(DW)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .take     (load),
        .full     (buf_full),
        .data     (buf_data)
    );

    utx_baud_gen #(.DIV_W(DIV_W), .OVS(utx_pkg::OVERSAMPLE)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .run      (busy),
        .restart  (load),
        .divisor  (divisor),
        .bit_end  (bit_end)
    );

    utx_frame_shift #(.DW(DW)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .bit_end     (bit_end),
        .data        (buf_data),
        .char_len    (char_len),
        .par_mode    (par_mode),
        .two_stop    (two_stop),
        .payload_inv (payload_inv),
        .busy        (busy),
        .line        (line),
        .frame_done  (frame_done)
    );

    always_comb begin
        load     = (!busy || frame_done) && buf_full && tx_en && (!cts_gate_en || !cts_n);
        st_d.irq = irq_sel ? frame_done : load;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign buf_empty = !buf_full;
    assign txd       = line ^ line_inv;
    assign irq       = st_q.irq;

    // R3: the buffer drains only under enable and clear-to-send
    p_start_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_full) |-> ($past(tx_en) && (!$past(cts_gate_en) || !$past(cts_n))));

    // R8: a take-cause pulse follows a buffer drain
    p_irq_on_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !$past(irq_sel)) |-> $fell(buf_full));

    // R9: an end-cause pulse follows a cycle in which a frame was active
    p_irq_on_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(irq_sel)) |-> $past(busy));
endmodule

// File: tb/uart_tx_core_tb.sv
module uart_tx_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_tick = 1'b1;
    logic       tick_half = 1'b0;
    logic [7:0] divisor = 8'd0;
    logic [1:0] char_len = 2'b01;
    logic [1:0] par_mode = 2'b00;
    logic       two_stop = 1'b0;
    logic       payload_inv = 1'b0;
    logic       line_inv = 1'b0;
    logic       tx_en = 1'b1;
    logic       cts_gate_en = 1'b0;
    logic       cts_n = 1'b1;
    logic       irq_sel = 1'b0;
    logic       wr_valid = 1'b0;
    logic [8:0] wr_data = 9'd0;
    logic       buf_empty, txd, irq;

    int    n_checks = 0;
    int    n_errors = 0;
    int    irq_cnt = 0;
    int    cyc = 0;
    string cur_req = "R1";

    // reference model state
    bit         m_full = 0;
    logic [8:0] m_data = '0;
    bit         m_busy = 0;
    bit         mq[$];
    int         m_cnt = 0;
    int         m_lim = 16;
    bit         m_irq = 0;

    uart_tx_core u_dut (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .divisor(divisor),
        .char_len(char_len), .par_mode(par_mode), .two_stop(two_stop),
        .payload_inv(payload_inv), .line_inv(line_inv), .tx_en(tx_en),
        .cts_gate_en(cts_gate_en), .cts_n(cts_n), .irq_sel(irq_sel),
        .wr_valid(wr_valid), .wr_data(wr_data), .buf_empty(buf_empty),
        .txd(txd), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic bit m_line();
        return m_busy ? mq[0] : 1'b1;
    endfunction

    // source tick pattern
    always @(posedge clk) begin
        #2;
        src_tick <= tick_half ? ~src_tick : 1'b1;
    end

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        bit be, last, ld, x, b;
        int nch;
        cyc++;
        if (!rst_n) begin
            m_full = 0; m_busy = 0; mq.delete(); m_cnt = 0; m_irq = 0;
        end else begin
            be   = m_busy && src_tick && (m_cnt == m_lim - 1);
            last = be && (mq.size() == 1);
            ld   = (!m_busy || last) && m_full && tx_en && (!cts_gate_en || !cts_n);
            m_irq = irq_sel ? last : ld;
            if (m_busy && src_tick) m_cnt = be ? 0 : m_cnt + 1;
            if (be) void'(mq.pop_front());
            if (last) m_busy = 0;
            if (ld) begin
                nch = (char_len == 2'b00) ? 7 : (char_len == 2'b10) ? 9 : 8;
                mq.delete();
                mq.push_back(1'b0);
                x = 0;
                for (int i = 0; i < nch; i++) begin
                    b = m_data[i] ^ payload_inv;
                    mq.push_back(b);
                    x ^= b;
                end
                if (par_mode == 2'b01) mq.push_back(x);
                if (par_mode == 2'b10) mq.push_back(!x);
                mq.push_back(1'b1);
                if (two_stop) mq.push_back(1'b1);
                m_busy = 1; m_cnt = 0; m_lim = 16 * (int'(divisor) + 1); m_full = 0;
            end else if (wr_valid && !m_full) begin
                m_full = 1; m_data = wr_data;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check(txd === (m_line() ^ line_inv), cur_req, "txd", int'(txd), int'(m_line() ^ line_inv));
            check(buf_empty === !m_full, cur_req, "buf_empty", int'(buf_empty), int'(!m_full));
            check(irq === m_irq, irq_sel ? "R9" : "R8", "irq", int'(irq), int'(m_irq));
            if (irq) irq_cnt++;
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog %s actual=%0d expected=%0d", cur_req, cyc, 150000);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic write_char(input logic [8:0] d);
        wr_valid = 1'b1; wr_data = d;
        step(1);
        wr_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 60000; k++) begin
            if (!m_busy && !m_full) break;
            step(1);
        end
        step(3);
    endtask

    initial begin
        step(5);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd === 1'b1, "R1", "idle txd", int'(txd), 1);
        check(buf_empty === 1'b1, "R1", "buf_empty", int'(buf_empty), 1);
        check(irq === 1'b0, "R1", "irq", int'(irq), 0);
        step(1);

        // R5 / R8: 8 data bits, no parity, one stop, take-cause interrupt
        cur_req = "R5"; irq_cnt = 0;
        write_char(9'h0A5);
        wait_idle();
        check(irq_cnt == 1, "R8", "irq pulses", irq_cnt, 1);

        // R6 / R7: 7 bits even parity two stops, then 9 bits odd parity
        cur_req = "R6"; char_len = 2'b00; par_mode = 2'b01; two_stop = 1'b1;
        write_char(9'h05B);
        wait_idle();
        cur_req = "R7"; char_len = 2'b10; par_mode = 2'b10;
        write_char(9'h1C3);
        wait_idle();
        two_stop = 1'b0; par_mode = 2'b00; char_len = 2'b01;

        // R9: end-cause interrupt
        cur_req = "R9"; irq_sel = 1'b1; irq_cnt = 0;
        write_char(9'h0F0);
        wait_idle();
        check(irq_cnt == 1, "R9", "irq pulses", irq_cnt, 1);
        irq_sel = 1'b0;

        // R3: enable and clear-to-send hold the start
        cur_req = "R3"; tx_en = 1'b0;
        write_char(9'h033);
        step(100);
        check(buf_empty === 1'b0, "R3", "held while disabled", int'(buf_empty), 0);
        check(txd === 1'b1, "R3", "idle while disabled", int'(txd), 1);
        cts_gate_en = 1'b1; cts_n = 1'b1; tx_en = 1'b1;
        step(100);
        check(buf_empty === 1'b0, "R3", "held by cts", int'(buf_empty), 0);
        cts_n = 1'b0;
        wait_idle();
        cts_gate_en = 1'b0; cts_n = 1'b1;

        // R2: write while full is dropped
        cur_req = "R2"; tx_en = 1'b0;
        write_char(9'h011);
        write_char(9'h022);
        check(buf_empty === 1'b0, "R2", "still full", int'(buf_empty), 0);
        tx_en = 1'b1;
        wait_idle();

        // R12: second character written while busy follows without a gap
        cur_req = "R12";
        write_char(9'h081);
        step(5);
        write_char(9'h07E);
        wait_idle();

        // R10: payload-only inversion with even parity
        cur_req = "R10"; payload_inv = 1'b1; par_mode = 2'b01;
        write_char(9'h00F);
        wait_idle();
        payload_inv = 1'b0; par_mode = 2'b00;

        // R11: whole-line inversion
        cur_req = "R11"; line_inv = 1'b1;
        step(3);
        @(negedge clk);
        check(txd === 1'b0, "R11", "inverted idle", int'(txd), 0);
        step(1);
        write_char(9'h096);
        wait_idle();
        line_inv = 1'b0;

        // R4: slower rate with a paused tick, then the largest divisor
        cur_req = "R4"; divisor = 8'd2; tick_half = 1'b1;
        write_char(9'h03C);
        wait_idle();
        tick_half = 1'b0; divisor = 8'd255; char_len = 2'b00;
        write_char(9'h055);
        wait_idle();
        divisor = 8'd0; char_len = 2'b01;

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule